// File: doc/BRIEF.md
# Bit-Masked Control Register Bank

This block holds the control fields of a receive-side serial PHY wrapper in a small bank of 32-bit registers. Each write carries its own bit-enable mask in bits 31:16. Only the lower-half bits whose mask bits are set take the new value, so software can change one field without first reading the register back. The mask half is never stored and always reads as zero.

Three control registers drive their fields out as separate ports: lane enables and lane mode forcing, a test-interface word, and turn requests with two clock-invert selects. A fourth offset is a read-only status word that returns the 8-bit test read-back value from the PHY. The bus is a plain valid/write/address/data interface. Writes take effect on the clock edge where valid is high. Read data is combinational and is valid in the same cycle as the request.

Top module: `mrb_top`

## Requirements
- R1: On a write, control bit n (n in 0..15) takes wdata[n] only when wdata[n+16] is 1 in the same write. Every other bit keeps its value.
- R2: Word offset 0 holds the lane receive enables in bits 3:0, the force-receive mode in bits 7:4, the force-stop state in bits 11:8 and the turnaround disable in bits 15:12. Each field is 4 bits wide.
- R3: Word offset 1 holds the 8-bit test data-in in bits 7:0, test-enable in bit 8, test-clock in bit 9 and test-clear in bit 10. Bits 15:11 read as zero and ignore writes.
- R4: Word offset 2 holds the 4-bit turn request in bits 3:0, clock-invert select A in bit 10 and clock-invert select B in bit 11. All other bits read as zero and ignore writes.
- R5: Word offset 3 is read-only. It returns the test data-out input in bits 7:0 and zero in all other bits, and writes to it change nothing.
- R6: A read (valid=1, write=0) returns the addressed register's 16 stored bits with bits 31:16 as zero. When no read is requested, the read data is zero.
- R7: A write to any offset other than 0..3 changes no register, and a read from such an offset returns zero.
- R8: A synchronous reset sets every control field to zero, except test-clock, which it sets to 1.
- R9: Writing mask 0x000F with data 0 to offset 0 clears all four lane enables and leaves the other fields of that register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Bits 31:16 are the mask, bits 15:0 are the data |
| bus_rdata | output | 32 | Read data, combinational |
| tst_dout | input | 8 | Test read-back value from the PHY |
| lane_en | output | 4 | Per-lane receive enable |
| force_rx | output | 4 | Force-receive mode per lane |
| force_stop | output | 4 | Force-stop state per lane |
| turn_dis | output | 4 | Turnaround disable per lane |
| tst_din | output | 8 | Test data-in |
| tst_en | output | 1 | Test enable |
| tst_clk | output | 1 | Test clock level |
| tst_clr | output | 1 | Test clear |
| turn_req | output | 4 | Turn request per lane |
| clkinv_a | output | 1 | Clock-invert select A |
| clkinv_b | output | 1 | Clock-invert select B |

## Verification
The bench writes with a full mask, with no mask, and with masks that cover only some bits of a field. A design that ignored the mask would overwrite neighbouring fields, and one that inverted the mask would leave the targeted bits unchanged. Writes go to the unimplemented bits of offsets 1 and 2, to the status word and to an undecoded offset, and every register is then read back. A decoder that aliased offsets or stored those bits would show non-zero bits where the requirements call for zero. The bench also checks that reset leaves test-clock high, which a design with a uniform zero reset would get wrong.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
   localparam int unsigned BUS_W   = 32;
   localparam int unsigned HALF_W  = BUS_W / 2;
   localparam int unsigned ADDR_W  = 4;
   localparam int unsigned N_CTRL  = 3;
   localparam int unsigned LANES   = 4;
   localparam int unsigned TDAT_W  = 8;

   localparam logic [ADDR_W-1:0] OFF_LANE = 4'd0;
   localparam logic [ADDR_W-1:0] OFF_TEST = 4'd1;
   localparam logic [ADDR_W-1:0] OFF_TURN = 4'd2;
   localparam logic [ADDR_W-1:0] OFF_STAT = 4'd3;

   // implemented bits of each control register
   localparam logic [HALF_W-1:0] IMPL_LANE = 16'hFFFF;
   localparam logic [HALF_W-1:0] IMPL_TEST = 16'h07FF;
   localparam logic [HALF_W-1:0] IMPL_TURN = 16'h0C0F;

   // reset values: test-clock (bit 9) is the only bit that resets high
   localparam logic [HALF_W-1:0] RST_LANE = 16'h0000;
   localparam logic [HALF_W-1:0] RST_TEST = 16'h0200;
   localparam logic [HALF_W-1:0] RST_TURN = 16'h0000;

   function automatic logic [HALF_W-1:0] impl_of(input int unsigned idx);
      case (idx)
         0:       impl_of = IMPL_LANE;
         1:       impl_of = IMPL_TEST;
         default: impl_of = IMPL_TURN;
      endcase
   endfunction

   function automatic logic [HALF_W-1:0] rst_of(input int unsigned idx);
      case (idx)
         0:       rst_of = RST_LANE;
         1:       rst_of = RST_TEST;
         default: rst_of = RST_TURN;
      endcase
   endfunction
endpackage

// File: rtl/mrb_mask_reg.sv
module mrb_mask_reg #(
   parameter int unsigned          W    = 16,
   parameter logic [W-1:0]         IMPL = '1,
   parameter logic [W-1:0]         RSTV = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic [W-1:0] wr_mask,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] q
);
   logic [W-1:0] eff_mask;

   if ((RSTV & ~IMPL) != '0) begin : g_bad_rst
      $error("mrb_mask_reg: reset value sets unimplemented bits");
   end

   assign eff_mask = wr_mask & IMPL;

   always_ff @(posedge clk) begin
      if (rst)
         q <= RSTV;
      else if (wr_en)
         q <= (q & ~eff_mask) | (wr_data & eff_mask);
   end

   // R1: bits outside the write mask never change
   a_r1_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (((q ^ $past(q)) & ~$past(wr_mask)) == '0));

   // R1: with no write, the register holds
   a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(q));

   // R3/R4: unimplemented bits stay clear
   a_r4_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
      (q & ~IMPL) == '0);
endmodule

// File: rtl/mrb_rd_mux.sv
module mrb_rd_mux
   import mrb_pkg::*;
#(
   parameter int unsigned NR = N_CTRL
) (
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [HALF_W-1:0]    regs [NR],
   input  logic [TDAT_W-1:0]    stat,
   output logic [BUS_W-1:0]     rdata
);
   logic [HALF_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NR; i++) begin
         if (addr == ADDR_W'(i)) sel = regs[i];
      end
      if (addr == OFF_STAT) sel = HALF_W'(stat);
   end

   assign rdata = rd_en ? {{(BUS_W-HALF_W){1'b0}}, sel} : '0;
endmodule

// File: rtl/mrb_top.sv
module mrb_top
   import mrb_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic [TDAT_W-1:0]    tst_dout,
   output logic [LANES-1:0]     lane_en,
   output logic [LANES-1:0]     force_rx,
   output logic [LANES-1:0]     force_stop,
   output logic [LANES-1:0]     turn_dis,
   output logic [TDAT_W-1:0]    tst_din,
   output logic                 tst_en,
   output logic                 tst_clk,
   output logic                 tst_clr,
   output logic [LANES-1:0]     turn_req,
   output logic                 clkinv_a,
   output logic                 clkinv_b
);
   logic [HALF_W-1:0] creg [N_CTRL];
   logic              rd_en;

   if (BUS_W != 2 * HALF_W || LANES * 4 > HALF_W) begin : g_bad_cfg
      $error("mrb_top: bus width does not fit the field layout");
   end

   assign rd_en = bus_valid && !bus_write;

   for (genvar i = 0; i < N_CTRL; i++) begin : g_reg
      logic hit;
      assign hit = bus_valid && bus_write && (bus_addr == ADDR_W'(i));
      mrb_mask_reg #(
         .W    (HALF_W),
         .IMPL (impl_of(i)),
         .RSTV (rst_of(i))
      ) u_reg (
         .clk     (clk),
         .rst     (rst),
         .wr_en   (hit),
         .wr_mask (bus_wdata[BUS_W-1:HALF_W]),
         .wr_data (bus_wdata[HALF_W-1:0]),
         .q       (creg[i])
      );
   end

   mrb_rd_mux #(.NR(N_CTRL)) u_rd (
      .rd_en (rd_en),
      .addr  (bus_addr),
      .regs  (creg),
      .stat  (tst_dout),
      .rdata (bus_rdata)
   );

   assign lane_en    = creg[OFF_LANE][3:0];
   assign force_rx   = creg[OFF_LANE][7:4];
   assign force_stop = creg[OFF_LANE][11:8];
   assign turn_dis   = creg[OFF_LANE][15:12];
   assign tst_din    = creg[OFF_TEST][7:0];
   assign tst_en     = creg[OFF_TEST][8];
   assign tst_clk    = creg[OFF_TEST][9];
   assign tst_clr    = creg[OFF_TEST][10];
   assign turn_req   = creg[OFF_TURN][3:0];
   assign clkinv_a   = creg[OFF_TURN][10];
   assign clkinv_b   = creg[OFF_TURN][11];

   // R6: mask half never returns on the bus
   a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
      bus_rdata[BUS_W-1:HALF_W] == '0);

   // R5: status offset reflects the read-back input
   a_r5_status_read: assert property (@(posedge clk) disable iff (rst)
      (rd_en && bus_addr == OFF_STAT) |-> bus_rdata == BUS_W'(tst_dout));

   // R7: undecoded offsets read as zero
   a_r7_undecoded_zero: assert property (@(posedge clk) disable iff (rst)
      (rd_en && bus_addr > OFF_STAT) |-> bus_rdata == '0);

   // R8: first cycle after reset: lanes off, test clock high
   a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (lane_en == '0 && tst_clk && !tst_en && turn_req == '0));

   // R5: a status write leaves every control field alone
   a_r5_status_nowrite: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && bus_write && bus_addr == OFF_STAT) |=>
         ($stable(lane_en) && $stable(tst_din) && $stable(turn_req)));
endmodule

// File: tb/sim_mrb_top.sv
module sim_mrb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        bus_valid, bus_write;
   logic [3:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic [7:0]  tst_dout;
   logic [3:0]  lane_en, force_rx, force_stop, turn_dis, turn_req;
   logic [7:0]  tst_din;
   logic        tst_en, tst_clk, tst_clr, clkinv_a, clkinv_b;
   int          n_chk = 0, n_err = 0;

   always #5 clk = ~clk;

   mrb_top u0 (.*);

   // {addr, write word, expected 16-bit read-back of that addr}
   localparam int NV = 11;
   localparam logic [51:0] VEC [NV] = '{
      {4'd0, 32'h000F_0005, 16'h0005},  // R1 R2 partial mask
      {4'd0, 32'h00F0_FFFF, 16'h00F5},  // R1 only force_rx
      {4'd0, 32'hF000_A000, 16'hA0F5},  // R2 turn_dis
      {4'd0, 32'h0000_FFFF, 16'hA0F5},  // R1 no mask
      {4'd1, 32'h00FF_003C, 16'h023C},  // R3 data-in, clk kept
      {4'd1, 32'h0200_0000, 16'h003C},  // R3 clear test-clock
      {4'd1, 32'hFF00_FFFF, 16'h073C},  // R3 unimplemented 15:11
      {4'd2, 32'hFFFF_FFFF, 16'h0C0F},  // R4 implemented only
      {4'd2, 32'h0401_0000, 16'h080E},  // R4 clear bit 10 and 0
      {4'd5, 32'hFFFF_FFFF, 16'h0000},  // R7 undecoded
      {4'd3, 32'hFFFF_FFFF, 16'h00A5}   // R5 status
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #1_000_000;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      logic [31:0] r;
      bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
      tst_dout = 8'hA5;
      @(negedge clk);
      do_reset();

      // R8 reset state
      chk("R8 lane", {16'b0, turn_dis, force_stop, force_rx, lane_en}, 32'h0);
      chk("R8 test", {21'b0, tst_clr, tst_clk, tst_en, tst_din}, 32'h0000_0200);
      chk("R8 turn", {26'b0, clkinv_b, clkinv_a, turn_req}, 32'h0);
      rd(4'd1, r); chk("R8 R6 read test", r, 32'h0000_0200);

      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][51:48], VEC[i][47:16]);
         rd(VEC[i][51:48], r);
         chk($sformatf("R1 R6 vector %0d", i), r, {16'h0, VEC[i][15:0]});
      end

      // R7/R5: the undecoded and status writes left every register alone
      rd(4'd0, r); chk("R7 lane kept", r, 32'h0000_A0F5);
      rd(4'd1, r); chk("R7 test kept", r, 32'h0000_073C);
      rd(4'd2, r); chk("R7 turn kept", r, 32'h0000_080E);
      rd(4'd15, r); chk("R7 top offset", r, 32'h0);

      // R2/R3/R4 fields at the ports
      chk("R2 ports", {16'b0, turn_dis, force_stop, force_rx, lane_en}, 32'h0000_A0F5);
      chk("R3 ports", {21'b0, tst_clr, tst_clk, tst_en, tst_din}, 32'h0000_073C);
      chk("R4 ports", {26'b0, clkinv_b, clkinv_a, turn_req}, 32'h0000_002E);

      // R5 status follows input
      tst_dout = 8'h3C;
      rd(4'd3, r); chk("R5 status", r, 32'h0000_003C);

      // R6 no read request -> zero
      bus_addr = 4'd0; #1;
      chk("R6 idle rdata", bus_rdata, 32'h0);
      @(negedge clk);

      // R9 lane disable keeps other fields
      wr(4'd0, 32'h000F_0000);
      chk("R9 lanes off", {28'b0, lane_en}, 32'h0);
      chk("R9 others kept", {16'b0, turn_dis, force_stop, force_rx, 4'b0}, 32'h0000_A0F0);

      // R8 reset again after activity
      do_reset();
      chk("R8 rereset test", {21'b0, tst_clr, tst_clk, tst_en, tst_din}, 32'h0000_0200);
      chk("R8 rereset lane", {16'b0, turn_dis, force_stop, force_rx, lane_en}, 32'h0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule